// File: doc/BRIEF.md
# Shared Cache Region Maintenance Engine

This block runs range-based maintenance on a shared second-level cache. Software programs it through a small register port. A control register selects the operation, a limit register holds the far end of the range, and a base register launches the work when it is written. For each cache line in the range, the engine issues one request on a tag-array handshake, waits for the acknowledge, and then moves to the next line. While the walk is running, a busy flag in the control register reads as 1.

The operation comes from a 3-bit region field and a separate mode bit. The field selects write-back or discard. The mode bit chooses whether a discard first writes dirty data back. Software writes the limit first and the base second. Address bits inside a line carry no meaning. A second trigger register starts a walk over every line of the cache from address zero. The line size is 128 or 64 bytes and comes from a strap input.

Top module: `rgnop_engine`

## Requirements
- R1: After reset, all four registers read 0, `tag_req` is 0 and `cache_off` is 0.
- R2: Writing the limit register (register address 1) starts no walk. A walk starts only on a write to the base register (address 2) or to the whole-cache register (address 3). Both registers read back the value last written.
- R3: When control bits [11:9] are 000, every line request carries `tag_op` 01, which means write back.
- R4: When control bits [11:9] are 001, `tag_op` is 10 (discard only) if control bit 6 is 0, and 11 (write back, then discard) if control bit 6 is 1.
- R5: A region walk requests line addresses in ascending order, one line per acknowledge. The first address is the base rounded down to a line. The walk stops below the limit rounded down to a line.
- R6: `line_sel` equal to 0 selects 128-byte lines. Any other value selects 64-byte lines. Every request address is aligned to the line size.
- R7: Control bit 8 (busy) reads 1 from the cycle after the triggering write until the cycle after the last acknowledge, and writes to it are ignored. A request holds its address and op stable until it is acknowledged.
- R8: A base write while busy is dropped: the walk in progress and the base register are unchanged. A limit write during a walk does not alter that walk.
- R9: A base write starts no walk if control bits [11:9] hold a value other than 000 or 001. It also starts no walk if the rounded limit is not above the rounded base. In both cases busy stays 0.
- R10: Writing 1 in bit 0 of register address 3 walks `ENTIRE_LINES` lines from address 0. The op is 11 if control bit 6 is set and 10 otherwise. Writing 0 there has no effect.
- R11: Control bit 0 is stored, reads back, and drives `cache_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_sel | input | 2 | Line size strap: 0 gives 128 B, other values give 64 B |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | ADDR_W | Register read data |
| cache_off | output | 1 | Stored cache-disable control |
| tag_req | output | 1 | Line request valid |
| tag_addr | output | ADDR_W | Line-aligned address of the request |
| tag_op | output | 2 | 01 write back, 10 discard, 11 write back then discard |
| tag_ack | input | 1 | Tag array accepts the current request |

## Verification
The assertions check on every cycle that a pending request holds its address and op until it is acknowledged. They also check that each acknowledge advances the address by exactly one line, that addresses stay aligned and below the limit, and that a walk begins only after a trigger write. The bench scenarios show things no single-cycle property can see. These are the full ordered list of lines and ops for each mode and line size, and the dropped base write during a busy walk. The bench also covers the reserved-field and empty-range cases, and the whole-cache sweep.

// File: rtl/rgnop_pkg.sv
package rgnop_pkg;
   typedef enum logic [1:0] {
      TAG_NONE  = 2'b00,
      TAG_FLUSH = 2'b01,
      TAG_INV   = 2'b10,
      TAG_FLINV = 2'b11
   } tag_op_e;

   localparam logic [1:0] REG_CTRL  = 2'd0;
   localparam logic [1:0] REG_END   = 2'd1;
   localparam logic [1:0] REG_START = 2'd2;
   localparam logic [1:0] REG_WIPE  = 2'd3;

   localparam int BIT_OFF  = 0;
   localparam int BIT_IM   = 6;
   localparam int BIT_BUSY = 8;
   localparam int RGN_LO   = 9;
   localparam int RGN_HI   = 11;

   localparam logic [2:0] RGN_FLUSH = 3'b000;
   localparam logic [2:0] RGN_INV   = 3'b001;
endpackage

// File: rtl/rgnop_geom.sv
module rgnop_geom #(
   parameter int ADDR_W   = 32,
   parameter int BIG_LOG2 = 7,
   parameter int SML_LOG2 = 6,
   parameter int SHW      = 3
) (
   input  logic [1:0]        line_sel,
   output logic [SHW-1:0]    line_shift,
   output logic [ADDR_W-1:0] line_mask
);
   initial assert (BIG_LOG2 < (1 << SHW) && SML_LOG2 < (1 << SHW) && BIG_LOG2 < ADDR_W);

   localparam logic [SHW-1:0] SH_BIG = SHW'(BIG_LOG2);
   localparam logic [SHW-1:0] SH_SML = SHW'(SML_LOG2);

   always_comb begin
      line_shift = (line_sel == 2'd0) ? SH_BIG : SH_SML;
      line_mask  = {ADDR_W{1'b1}} << line_shift;
   end
endmodule

// File: rtl/rgnop_walker.sv
module rgnop_walker
   import rgnop_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SHW    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_base,
   input  logic [ADDR_W:0]   go_limit,
   input  tag_op_e           go_op,
   input  logic [SHW-1:0]    go_shift,
   output logic              busy,
   output logic              tag_req,
   output logic [ADDR_W-1:0] tag_addr,
   output tag_op_e           tag_op,
   input  logic              tag_ack
);
   localparam int CW = ADDR_W + 1;

   logic           busy_q;
   logic [CW-1:0]  cur_q, lim_q, step, nxt;
   tag_op_e        op_q;
   logic [SHW-1:0] shift_q;
   logic [ADDR_W-1:0] low_bits;

   always_comb begin
      step     = CW'(1) << shift_q;
      nxt      = cur_q + step;
      low_bits = ~({ADDR_W{1'b1}} << shift_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cur_q   <= '0;
         lim_q   <= '0;
         op_q    <= TAG_NONE;
         shift_q <= '0;
      end else if (!busy_q) begin
         if (go && (go_limit > {1'b0, go_base})) begin
            busy_q  <= 1'b1;
            cur_q   <= {1'b0, go_base};
            lim_q   <= go_limit;
            op_q    <= go_op;
            shift_q <= go_shift;
         end
      end else if (tag_ack) begin
         if (nxt >= lim_q) busy_q <= 1'b0;
         else              cur_q  <= nxt;
      end
   end

   assign busy     = busy_q;
   assign tag_req  = busy_q;
   assign tag_addr = cur_q[ADDR_W-1:0];
   assign tag_op   = busy_q ? op_q : TAG_NONE;

   assert_hold_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req && !tag_ack |=> tag_req && $stable(tag_addr) && $stable(tag_op));

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req && tag_ack |=> !tag_req || (tag_addr == $past(tag_addr) + (ADDR_W'(1) << shift_q)));

   assert_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req |-> ({1'b0, tag_addr} < lim_q));

   assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req |-> ((tag_addr & low_bits) == '0));
endmodule

// File: rtl/rgnop_regs.sv
module rgnop_regs
   import rgnop_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int SHW          = 3,
   parameter bit HAS_ENTIRE   = 1'b1,
   parameter int ENTIRE_LINES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        waddr,
   input  logic [ADDR_W-1:0] wdata,
   input  logic [1:0]        raddr,
   output logic [ADDR_W-1:0] rdata,
   input  logic              busy,
   input  logic [SHW-1:0]    line_shift,
   input  logic [ADDR_W-1:0] line_mask,
   output logic              go,
   output logic [ADDR_W-1:0] go_base,
   output logic [ADDR_W:0]   go_limit,
   output tag_op_e           go_op,
   output logic [SHW-1:0]    go_shift,
   output logic              cache_off
);
   initial assert (ADDR_W > RGN_HI && ENTIRE_LINES > 0);

   logic              off_q, im_q;
   logic [2:0]        rgn_q;
   logic [ADDR_W-1:0] end_q, start_q;
   logic              launch_rgn, launch_all, rgn_legal;
   tag_op_e           rgn_op, all_op;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q   <= 1'b0;
         im_q    <= 1'b0;
         rgn_q   <= RGN_FLUSH;
         end_q   <= '0;
         start_q <= '0;
      end else if (wr) begin
         case (waddr)
            REG_CTRL: begin
               off_q <= wdata[BIT_OFF];
               im_q  <= wdata[BIT_IM];
               rgn_q <= wdata[RGN_HI:RGN_LO];
            end
            REG_END:   end_q <= wdata;
            REG_START: if (!busy) start_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rgn_legal  = (rgn_q == RGN_FLUSH) || (rgn_q == RGN_INV);
      launch_rgn = wr && (waddr == REG_START) && !busy && rgn_legal;
      rgn_op     = (rgn_q == RGN_FLUSH) ? TAG_FLUSH : (im_q ? TAG_FLINV : TAG_INV);
      all_op     = im_q ? TAG_FLINV : TAG_INV;
   end

   generate
      if (HAS_ENTIRE) begin : g_entire
         assign launch_all = wr && (waddr == REG_WIPE) && wdata[0] && !busy;
      end else begin : g_no_entire
         assign launch_all = 1'b0;
      end
   endgenerate

   always_comb begin
      go       = launch_rgn || launch_all;
      go_shift = line_shift;
      if (launch_all) begin
         go_base  = '0;
         go_limit = (ADDR_W+1)'(ENTIRE_LINES) << line_shift;
         go_op    = all_op;
      end else begin
         go_base  = wdata & line_mask;
         go_limit = {1'b0, end_q & line_mask};
         go_op    = rgn_op;
      end
   end

   always_comb begin
      rdata = '0;
      case (raddr)
         REG_CTRL: begin
            rdata[BIT_OFF]       = off_q;
            rdata[BIT_IM]        = im_q;
            rdata[BIT_BUSY]      = busy;
            rdata[RGN_HI:RGN_LO] = rgn_q;
         end
         REG_END:   rdata = end_q;
         REG_START: rdata = start_q;
         default:   rdata = '0;
      endcase
   end

   assign cache_off = off_q;

   assert_ctrl_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr && (waddr == REG_CTRL) |=> cache_off == $past(wdata[BIT_OFF]));

   assert_start_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr && (waddr == REG_START) |=> $stable(start_q));
endmodule

// File: rtl/rgnop_engine.sv
module rgnop_engine
   import rgnop_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int BIG_LOG2     = 7,
   parameter int SML_LOG2     = 6,
   parameter bit HAS_ENTIRE   = 1'b1,
   parameter int ENTIRE_LINES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        line_sel,
   input  logic              reg_wr,
   input  logic [1:0]        reg_waddr,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic [1:0]        reg_raddr,
   output logic [ADDR_W-1:0] reg_rdata,
   output logic              cache_off,
   output logic              tag_req,
   output logic [ADDR_W-1:0] tag_addr,
   output logic [1:0]        tag_op,
   input  logic              tag_ack
);
   localparam int SHW = $clog2(ADDR_W);

   logic [SHW-1:0]    line_shift, go_shift;
   logic [ADDR_W-1:0] line_mask, go_base;
   logic [ADDR_W:0]   go_limit;
   logic              go, busy;
   tag_op_e           go_op, op_w;

   rgnop_geom #(.ADDR_W(ADDR_W), .BIG_LOG2(BIG_LOG2), .SML_LOG2(SML_LOG2), .SHW(SHW)) u_geom (
      .line_sel(line_sel), .line_shift(line_shift), .line_mask(line_mask));

   rgnop_regs #(.ADDR_W(ADDR_W), .SHW(SHW), .HAS_ENTIRE(HAS_ENTIRE),
                .ENTIRE_LINES(ENTIRE_LINES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
      .raddr(reg_raddr), .rdata(reg_rdata), .busy(busy), .line_shift(line_shift),
      .line_mask(line_mask), .go(go), .go_base(go_base), .go_limit(go_limit),
      .go_op(go_op), .go_shift(go_shift), .cache_off(cache_off));

   rgnop_walker #(.ADDR_W(ADDR_W), .SHW(SHW)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(go), .go_base(go_base), .go_limit(go_limit),
      .go_op(go_op), .go_shift(go_shift), .busy(busy), .tag_req(tag_req),
      .tag_addr(tag_addr), .tag_op(op_w), .tag_ack(tag_ack));

   assign tag_op = op_w;

   assert_launch_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tag_req) |-> $past(reg_wr) &&
         (($past(reg_waddr) == REG_START) || ($past(reg_waddr) == REG_WIPE)));

   assert_op_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tag_req |-> (tag_op != 2'b00));
endmodule

// File: tb/test_rgnop_engine.sv
module test_rgnop_engine;
   localparam int NLINES = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  line_sel = 2'd0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_waddr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_raddr = 2'd0;
   logic [31:0] reg_rdata;
   logic        cache_off, tag_req, tag_ack;
   logic [31:0] tag_addr;
   logic [1:0]  tag_op;

   int checks = 0;
   int fails  = 0;
   logic [33:0] exp_q[$];

   always #10 clk = ~clk;

   rgnop_engine #(.ENTIRE_LINES(NLINES)) i_rgnop_engine (
      .clk(clk), .rst_n(rst_n), .line_sel(line_sel), .reg_wr(reg_wr),
      .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
      .reg_rdata(reg_rdata), .cache_off(cache_off), .tag_req(tag_req),
      .tag_addr(tag_addr), .tag_op(tag_op), .tag_ack(tag_ack));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   // expected line list: floor(base) up to below floor(limit)
   task automatic push_walk(input logic [31:0] s, input logic [31:0] e, input logic [1:0] op, input int sh);
      logic [31:0] lim;
      lim = (e >> sh) << sh;
      for (logic [32:0] a = {1'b0, (s >> sh) << sh}; a < {1'b0, lim}; a += (33'd1 << sh))
         exp_q.push_back({op, a[31:0]});
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] d;
      int n = 0;
      do begin
         @(negedge clk);
         read_reg(2'd0, d);
         n++;
      end while (d[8] && n < 5000);
      chk(d[8] == 1'b0, req, d[8], 0);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   // tag-array stub and scoreboard monitor
   initial begin
      int gap = 0;
      int nacks = 0;
      tag_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (tag_req) begin
            if (gap == 0) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5 unexpected request", {30'd0, tag_op, tag_addr}, 0);
               end else begin
                  logic [33:0] e;
                  e = exp_q.pop_front();
                  chk({tag_op, tag_addr} == e, "R5 line/op order", {30'd0, tag_op, tag_addr}, {30'd0, e});
               end
               tag_ack = 1'b1;
               gap = nacks % 3;
               nacks++;
            end else begin
               tag_ack = 1'b0;
               gap--;
            end
         end else begin
            tag_ack = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog actual=hang expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int r = 0; r < 4; r++) begin
         read_reg(r[1:0], d);
         chk(d == 0, "R1 register reset", d, 0);
      end
      chk(tag_req == 1'b0, "R1 tag_req reset", tag_req, 0);
      chk(cache_off == 1'b0, "R1 cache_off reset", cache_off, 0);

      // R2 limit write alone does not launch; R3 write-back walk, 128 B lines
      reg_write(2'd0, 32'h0000_0000);
      reg_write(2'd1, 32'h0000_12BF);
      chk(tag_req == 1'b0, "R2 limit write launched", tag_req, 0);
      read_reg(2'd1, d);
      chk(d == 32'h12BF, "R2 limit readback", d, 32'h12BF);
      push_walk(32'h1040, 32'h12BF, 2'b01, 7);
      chk(exp_q.size() == 5, "R3 expected list", exp_q.size(), 5);
      reg_write(2'd2, 32'h0000_1040);
      read_reg(2'd0, d);
      chk(d[8] == 1'b1, "R7 busy after start write", d[8], 1);
      read_reg(2'd2, d);
      chk(d == 32'h1040, "R2 base readback", d, 32'h1040);
      wait_idle("R3 flush walk");

      // R4 discard-only, R6 64 B lines
      line_sel = 2'd1;
      reg_write(2'd0, 32'h0000_0200);
      push_walk(32'h2000, 32'h20FF, 2'b10, 6);
      reg_write(2'd1, 32'h0000_20FF);
      reg_write(2'd2, 32'h0000_2000);
      wait_idle("R4 R6 discard walk");

      // R4 write back then discard, R6 line_sel=2 also 64 B
      line_sel = 2'd2;
      reg_write(2'd0, 32'h0000_0240);
      push_walk(32'h3010, 32'h30BF, 2'b11, 6);
      reg_write(2'd1, 32'h0000_30BF);
      reg_write(2'd2, 32'h0000_3010);
      wait_idle("R4 R6 flush-discard walk");

      // R8 base and limit writes during a walk
      line_sel = 2'd0;
      reg_write(2'd0, 32'h0000_0000);
      push_walk(32'h8000, 32'h847F, 2'b01, 7);
      reg_write(2'd1, 32'h0000_847F);
      reg_write(2'd2, 32'h0000_8000);
      reg_write(2'd2, 32'h0000_9000);
      reg_write(2'd1, 32'h0000_FFFF);
      wait_idle("R8 walk unchanged by writes");
      read_reg(2'd2, d);
      chk(d == 32'h8000, "R8 base write while busy dropped", d, 32'h8000);
      read_reg(2'd1, d);
      chk(d == 32'hFFFF, "R8 limit register updated", d, 32'hFFFF);

      // R9 reserved region field
      reg_write(2'd0, 32'h0000_0600);
      reg_write(2'd2, 32'h0000_1000);
      read_reg(2'd0, d);
      chk(d[8] == 1'b0, "R9 reserved op busy", d[8], 0);
      chk(tag_req == 1'b0, "R9 reserved op request", tag_req, 0);

      // R9 empty range
      reg_write(2'd0, 32'h0000_0000);
      reg_write(2'd1, 32'h0000_5050);
      reg_write(2'd2, 32'h0000_5000);
      read_reg(2'd0, d);
      chk(d[8] == 1'b0, "R9 empty range busy", d[8], 0);
      chk(tag_req == 1'b0, "R9 empty range request", tag_req, 0);

      // R7 busy bit not writable
      reg_write(2'd0, 32'h0000_0100);
      read_reg(2'd0, d);
      chk(d[8] == 1'b0, "R7 busy write ignored", d[8], 0);

      // R10 whole cache: value 0 ignored, then mode bit set
      reg_write(2'd0, 32'h0000_0040);
      reg_write(2'd3, 32'h0000_0000);
      read_reg(2'd0, d);
      chk(d[8] == 1'b0, "R10 zero write ignored", d[8], 0);
      chk(tag_req == 1'b0, "R10 zero write request", tag_req, 0);
      push_walk(32'h0, NLINES * 128, 2'b11, 7);
      reg_write(2'd3, 32'h0000_0001);
      wait_idle("R10 whole-cache flush-discard");
      line_sel = 2'd3;
      reg_write(2'd0, 32'h0000_0000);
      push_walk(32'h0, NLINES * 64, 2'b10, 6);
      reg_write(2'd3, 32'h0000_0001);
      wait_idle("R10 whole-cache discard");

      // R11 disable bit
      reg_write(2'd0, 32'h0000_0001);
      chk(cache_off == 1'b1, "R11 cache_off set", cache_off, 1);
      read_reg(2'd0, d);
      chk(d[0] == 1'b1, "R11 readback", d[0], 1);
      reg_write(2'd0, 32'h0000_0000);
      chk(cache_off == 1'b0, "R11 cache_off clear", cache_off, 0);

      summary();
      $finish;
   end
endmodule